// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns one asynchronous serial input line into characters. A frame has a low start bit, 7 or 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. An external clock enable pulses at sixteen times the bit rate. Each bit is sampled once, at the middle of the bit.

Each finished character is written to a data register. A status register holds four flags: data-ready, overrun, framing error and parity error. Software uses a small register port with separate read and write strobes. It reads the data and status, and it clears the flags.

A bad frame still updates the data register, but it does not raise data-ready. While either error flag is set, the receiver stays idle and accepts no new frames. Software clears an error flag, or the overrun flag, in two steps. First it reads the status register while the flag is 1. Then it writes 0 to that flag's bit.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, the status register reads 0x00 and the data register reads 0x00.
- R2: A frame with no errors loads its data bits into the data register, least significant bit first. It also sets data-ready (status bit 7). With 7-bit length selected, bit 7 of the data register reads 0.
- R3: The start bit is checked again 8 oversample ticks after the falling edge. If the line is high at that point, no frame is received and the status is unchanged.
- R4: The framing-error flag (status bit 5) is set when the first stop bit is sampled low. With two stop bits selected, the value of the second stop bit has no effect.
- R5: With parity enabled, the parity-error flag (status bit 4) is set when the data bits plus the parity bit do not hold an even number of ones (even mode) or an odd number of ones (odd mode, `cfg_par_odd`=1).
- R6: A frame with a framing or parity error still writes its data to the data register, and data-ready stays 0.
- R7: While either error flag is 1, frames on the line are ignored. The data register and data-ready do not change.
- R8: A write to the status register (address 1) with 0 in an error flag's bit clears that flag only if an earlier status read returned the flag as 1. A write of 0 without such a read leaves the flag set.
- R9: While `rx_enable` is 0, no frame is received, and the error flags keep their values.
- R10: Reading the data register (address 0) clears data-ready. If a frame with no errors completes while data-ready is 1, the new data replaces the old data and the overrun flag (status bit 6) is set. Overrun clears by the same read-then-write-0 rule as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_x16_en | input | 1 | Clock enable at 16 times the bit rate |
| rx_in | input | 1 | Serial input line, high when idle |
| rx_enable | input | 1 | Receiver enable |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Frame has two stop bits |
| reg_addr | input | 1 | 0 selects the data register, 1 the status register |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |

## Verification
A wrong bit counter or a wrong sampling phase puts shifted or corrupted data in the data register at the end of the frame. A missed error shows up as data-ready set when only an error flag should be. The blocking and two-step clear rules are internal state. A fault in them shows up one frame later: a frame gets through while an error is set, or a flag stays set (or goes away) against the read-then-write sequence. For that reason the bench sends a second frame after each error and reads the status before and after every clear attempt.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_x16_en,
  input  logic       rx_in,
  input  logic       rx_enable,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t             state;
  logic [CW-1:0]   cnt;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg, rdr;
  logic            par_q;
  logic [SYNC-1:0] sync_q;
  logic            full_q, ovr_q, fe_q, pe_q;
  logic            arm_fe, arm_pe, arm_ovr;

  wire rx_s       = sync_q[SYNC-1];
  wire blocked    = fe_q | pe_q;
  wire [2:0] last_idx = cfg_len7 ? 3'd6 : 3'd7;
  wire frame_done = rx_enable && baud_x16_en && state == S_STOP1 && cnt == LAST;
  wire ones_odd   = ^shreg ^ par_q;
  wire par_bad    = cfg_par_en & (cfg_par_odd ? ~ones_odd : ones_odd);
  wire stop_bad   = ~rx_s;
  wire frame_bad  = par_bad | stop_bad;
  wire rd_data    = reg_rd & ~reg_addr;
  wire rd_stat    = reg_rd & reg_addr;
  wire wr_stat    = reg_wr & reg_addr;

  assign reg_rdata = reg_addr ? {full_q, ovr_q, fe_q, pe_q, 4'b0000} : rdr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bit_idx <= '0; shreg <= '0; par_q <= 1'b0;
    end else if (!rx_enable) begin
      state <= S_IDLE;
    end else if (baud_x16_en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (!rx_s && !blocked) state <= S_START;
        end
        S_START:
          if (cnt == MID) begin
            cnt <= '0; bit_idx <= '0; shreg <= '0; par_q <= 1'b0;
            state <= rx_s ? S_IDLE : S_DATA;
          end
        S_DATA:
          if (cnt == LAST) begin
            shreg[bit_idx] <= rx_s;
            if (bit_idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP1;
            else bit_idx <= bit_idx + 1'b1;
          end
        S_PAR:
          if (cnt == LAST) begin
            par_q <= rx_s;
            state <= S_STOP1;
          end
        S_STOP1:
          if (cnt == LAST) state <= cfg_two_stop ? S_STOP2 : S_IDLE;
        S_STOP2:
          if (cnt == LAST) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr <= '0; full_q <= 1'b0; ovr_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
      arm_fe <= 1'b0; arm_pe <= 1'b0; arm_ovr <= 1'b0;
    end else begin
      if (rd_stat) begin
        arm_fe  <= arm_fe  | fe_q;
        arm_pe  <= arm_pe  | pe_q;
        arm_ovr <= arm_ovr | ovr_q;
      end
      if (wr_stat && !reg_wdata[5] && arm_fe)  begin fe_q  <= 1'b0; arm_fe  <= 1'b0; end
      if (wr_stat && !reg_wdata[4] && arm_pe)  begin pe_q  <= 1'b0; arm_pe  <= 1'b0; end
      if (wr_stat && !reg_wdata[6] && arm_ovr) begin ovr_q <= 1'b0; arm_ovr <= 1'b0; end
      if (rd_data) full_q <= 1'b0;
      if (frame_done) begin
        rdr <= shreg;
        if (stop_bad) fe_q <= 1'b1;
        if (par_bad)  pe_q <= 1'b1;
        if (!frame_bad) begin
          full_q <= 1'b1;
          if (full_q && !rd_data) ovr_q <= 1'b1;
        end
      end
    end
  end

  AST_GOOD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_bad |=> full_q); // R2
  AST_BAD_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_bad && !rd_data |=> full_q == $past(full_q)); // R6
  AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && state == S_IDLE |=> state == S_IDLE); // R7
  AST_FE_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_q) |-> $past(arm_fe)); // R8
  AST_PE_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pe_q) |-> $past(arm_pe)); // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> state == S_IDLE); // R9
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_bad && full_q && !rd_data |=> ovr_q); // R10
endmodule

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;
  logic clk = 0, rst_n = 0, tick = 0, rx_in = 1, rx_enable = 1;
  logic cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic reg_addr = 0, reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  int checks = 0, errors = 0;

  typedef struct { logic [7:0] data; logic fe; logic pe; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .baud_x16_en(tick), .rx_in(rx_in), .rx_enable(rx_enable),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); rx_in = b;
    repeat (31) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip_par, input logic stop1,
                      input logic stop2, input logic push);
    logic [7:0] dm;
    logic p;
    exp_t e;
    dm = cfg_len7 ? (d & 8'h7f) : d;
    p = (^dm) ^ cfg_par_odd ^ flip_par;
    bit_out(1'b0);
    for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) bit_out(dm[i]);
    if (cfg_par_en) bit_out(p);
    bit_out(stop1);
    if (cfg_two_stop) bit_out(stop2);
    @(negedge clk); rx_in = 1;
    repeat (64) @(negedge clk);
    if (push) begin
      e.data = dm; e.fe = ~stop1; e.pe = cfg_par_en & flip_par;
      q.push_back(e);
      wait (q.size() == 0);
    end
  endtask

  initial begin : monitor
    exp_t e;
    logic [7:0] v;
    logic good;
    forever begin
      wait (q.size() != 0);
      e = q[0];
      good = !e.fe && !e.pe;
      rd(1'b1, v); chk("R2/R4/R5 status after frame", v, {good, 1'b0, e.fe, e.pe, 4'b0});
      rd(1'b0, v); chk("R2/R6 data register", v, e.data);
      if (!good) wr(1'b1, 8'h00);
      rd(1'b1, v); chk("R8/R10 status after read and clear", v, 8'h00);
      void'(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) @(negedge clk); rst_n = 1;
    rd(1'b1, v); chk("R1 status reset", v, 8'h00);
    rd(1'b0, v); chk("R1 data reset", v, 8'h00);

    send(8'hA5, 0, 1, 1, 1);                         // R2
    send(8'h3C, 0, 1, 1, 1);                         // R2
    cfg_par_en = 1; cfg_par_odd = 0;
    send(8'h96, 0, 1, 1, 1);                         // R5 even ok
    send(8'h01, 1, 1, 1, 1);                         // R5 even bad
    cfg_par_odd = 1;
    send(8'h7E, 0, 1, 1, 1);                         // R5 odd ok
    send(8'hC3, 1, 1, 1, 1);                         // R5 odd bad
    cfg_par_en = 0; cfg_len7 = 1;
    send(8'hFF, 0, 1, 1, 1);                         // R2 7-bit
    cfg_len7 = 0;
    send(8'h5A, 0, 0, 1, 1);                         // R4 stop low
    cfg_two_stop = 1;
    send(8'h69, 0, 1, 0, 1);                         // R4 second stop ignored
    send(8'h18, 0, 0, 1, 1);                         // R4 first stop checked
    cfg_two_stop = 0;

    // R3: short low pulse is not a start bit
    @(negedge clk); rx_in = 0; repeat (8) @(negedge clk); rx_in = 1;
    repeat (400) @(negedge clk);
    rd(1'b1, v); chk("R3 glitch ignored status", v, 8'h00);
    send(8'h42, 0, 1, 1, 1);                         // R3 reception recovers

    // R10: overrun
    send(8'h11, 0, 1, 1, 0);
    send(8'h22, 0, 1, 1, 0);
    rd(1'b1, v); chk("R10 overrun status", v, 8'hC0);
    rd(1'b0, v); chk("R10 overwritten data", v, 8'h22);
    rd(1'b1, v); chk("R10 data read clears ready", v, 8'h40);
    wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R10 overrun cleared", v, 8'h00);

    // R7/R8/R6/R9
    send(8'h55, 0, 0, 1, 0);
    wr(1'b1, 8'h00);                                 // R8 write without read
    send(8'hAA, 0, 1, 1, 0);                         // R7 should be ignored
    rd(1'b1, v); chk("R8 flag kept, R7 blocked", v, 8'h20);
    rd(1'b0, v); chk("R6/R7 data from bad frame kept", v, 8'h55);
    rx_enable = 0; repeat (50) @(negedge clk);
    rd(1'b1, v); chk("R9 flag kept while disabled", v, 8'h20);
    rx_enable = 1;
    wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R8 cleared after read", v, 8'h00);
    rx_enable = 0;
    send(8'h33, 0, 1, 1, 0);
    rd(1'b1, v); chk("R9 disabled frame ignored status", v, 8'h00);
    rd(1'b0, v); chk("R9 disabled frame ignored data", v, 8'h55);
    rx_enable = 1;
    send(8'hE7, 0, 1, 1, 1);                         // R7 resumes

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule